// File: doc/BRIEF.md
# Mini-Float Multiplier

This block multiplies two numbers held in a compact 11-bit floating-point word. Each word packs a sign bit at bit 10, a 4-bit biased exponent in bits 9:6 (bias 7) and a 6-bit fraction in bits 5:0 that sits behind an implicit leading one. The block forms the full 7-bit significands, takes their 14-bit product and renormalizes it. It rounds to nearest with ties to even, using a guard bit and a sticky bit. It then rebuilds the biased exponent and gives the result the exclusive-OR of the operand signs.

A stored exponent of 0 means zero, and its fraction is ignored because subnormals are not supported. A stored exponent of 15 means infinity when the fraction is zero and NaN otherwise. Results that fall outside the normal range saturate to infinity or flush to zero, and a flag reports each case. One result leaves the block per accepted operand pair, one clock cycle after the pair is presented.

Top module: `fp11_mul`

## Requirements
- R1: For two normal operands (stored exponent 1..14), the result exponent field equals ea + eb - 7, plus the normalization and rounding increments. The result fraction holds the rounded significand product without its leading one.
- R2: For every non-NaN result, the result sign (bit 10) equals op_a[10] XOR op_b[10].
- R3: When the 14-bit significand product is 2.0 or more (top bit set), it is shifted right by one place and the exponent is incremented by one.
- R4: Rounding is to nearest. A discarded part of exactly half an ulp rounds to the neighbour with an even fraction LSB.
- R5: When rounding carries out of the 7-bit significand, the fraction becomes 0 and the exponent is incremented by one more.
- R6: Zero (stored exponent 0) times zero or a normal value gives a zero with the R2 sign, and no flag is raised.
- R7: Infinity times zero gives the canonical NaN 0_1111_100000 and sets inv. A NaN operand gives the same canonical NaN with inv clear.
- R8: Infinity times infinity or a normal value gives a correctly signed infinity (exponent 15, fraction 0) with no flag.
- R9: A finite product whose final exponent would be 15 or more gives a signed infinity and sets ovf.
- R10: A finite product whose final exponent would be 0 or less gives a signed zero and sets unf.
- R11: out_valid rises exactly one cycle after in_valid. Without in_valid, the result and flags hold their values.
- R12: After reset, out_valid, result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 11 | First operand |
| op_b | input | 11 | Second operand |
| out_valid | output | 1 | Result registered from last cycle's operands |
| result | output | 11 | Product word |
| ovf | output | 1 | Result saturated to infinity |
| unf | output | 1 | Result flushed to zero |
| inv | output | 1 | Infinity times zero |

## Verification
The bench targets exact half-ulp ties with odd and even fraction LSBs. A design that rounds half-up gets the even case wrong by one ulp. It also drives an operand pair whose product rounds up past 1.111111. A design that ignores that carry returns a zero fraction with an exponent one too low. Directed pairs then sit exactly at both ends of the exponent range, where an off-by-one bias test either overflows early or leaks an exponent of 0 or 15. Infinity times zero and NaN inputs check that inv is raised only for the first case.

// File: rtl/fp11_pkg.sv
package fp11_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_cls_e;
endpackage

// File: rtl/fp11_unpack.sv
module fp11_unpack
    import fp11_pkg::*;
#(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 6,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [FRAC_W-1:0] frac,
    output fp_cls_e           cls
);
    always_comb begin
        sign = word[WORD_W-1];
        expo = word[WORD_W-2 -: EXP_W];
        frac = word[FRAC_W-1:0];
        if (expo == '0)
            cls = CLS_ZERO;
        else if (expo == '1)
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/fp11_sig_mul.sv
module fp11_sig_mul #(
    parameter int FRAC_W = 6,
    localparam int SW = FRAC_W + 1,
    localparam int PW = 2 * SW
) (
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    output logic [FRAC_W-1:0] frac_o,
    output logic [1:0]        exp_adj
);
    logic [PW-1:0]   prod;
    logic            hi;
    logic [PW-2:0]   norm;
    logic [FRAC_W-1:0] mant;
    logic            guard;
    logic            sticky;
    logic            rnd_up;
    logic [FRAC_W:0] rsum;

    always_comb begin
        prod   = PW'({1'b1, frac_a}) * PW'({1'b1, frac_b});
        hi     = prod[PW-1];
        // drop the leading one, aligning it just above bit PW-2
        norm   = hi ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        mant   = norm[PW-2 -: FRAC_W];
        guard  = norm[PW-2-FRAC_W];
        sticky = |norm[PW-3-FRAC_W:0];
        rnd_up = guard & (sticky | mant[0]);
        rsum   = {1'b0, mant} + {{FRAC_W{1'b0}}, rnd_up};
        frac_o = rsum[FRAC_W-1:0];
        exp_adj = {1'b0, hi} + {1'b0, rsum[FRAC_W]};
    end
endmodule

// File: rtl/fp11_mul.sv
module fp11_mul
    import fp11_pkg::*;
#(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 6,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf,
    output logic              inv
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int EW      = EXP_W + 3;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              unf;
        logic              inv;
    } st_t;

    st_t st_d, st_q;

    logic              sa, sb, s_res;
    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb, f_rnd;
    fp_cls_e           ca, cb;
    logic [1:0]        adj;
    logic [EW-1:0]     e_sum;

    fp11_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word(op_a), .sign(sa), .expo(ea), .frac(fa), .cls(ca)
    );
    fp11_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word(op_b), .sign(sb), .expo(eb), .frac(fb), .cls(cb)
    );
    fp11_sig_mul #(.FRAC_W(FRAC_W)) u_sig (
        .frac_a(fa), .frac_b(fb), .frac_o(f_rnd), .exp_adj(adj)
    );

    always_comb begin
        s_res = sa ^ sb;
        e_sum = EW'(ea) + EW'(eb) + EW'(adj) - EW'(BIAS);

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
            st_d.inv = 1'b0;
            if (ca == CLS_NAN || cb == CLS_NAN) begin
                st_d.res = QNAN;
            end else if ((ca == CLS_INF && cb == CLS_ZERO) ||
                         (ca == CLS_ZERO && cb == CLS_INF)) begin
                st_d.res = QNAN;
                st_d.inv = 1'b1;
            end else if (ca == CLS_INF || cb == CLS_INF) begin
                st_d.res = {s_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (ca == CLS_ZERO || cb == CLS_ZERO) begin
                st_d.res = {s_res, {(WORD_W-1){1'b0}}};
            end else if ($signed(e_sum) >= EXP_TOP) begin
                st_d.res = {s_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                st_d.ovf = 1'b1;
            end else if ($signed(e_sum) < 1) begin
                st_d.res = {s_res, {(WORD_W-1){1'b0}}};
                st_d.unf = 1'b1;
            end else begin
                st_d.res = {s_res, e_sum[EXP_W-1:0], f_rnd};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign ovf       = st_q.ovf;
    assign unf       = st_q.unf;
    assign inv       = st_q.inv;
endmodule

// File: rtl/fp11_mul_chk.sv
module fp11_mul_chk #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 6,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf,
    input logic              unf,
    input logic              inv
);
    logic res_nan;
    assign res_nan = (result[WORD_W-2 -: EXP_W] == '1) && (result[FRAC_W-1:0] != '0);

    // R11
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable({ovf, unf, inv})));
    // R2
    a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_nan || result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])));
    // R9
    a_r9_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] == '0));
    // R10
    a_r10_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (result[WORD_W-2:0] == '0));
    // R7
    a_r7_inv_nan: assert property (@(posedge clk) disable iff (!rst_n)
        inv |-> res_nan);
    // R7 R9 R10
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf, unf, inv}));
endmodule

bind fp11_mul fp11_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf), .inv(inv)
);

// File: tb/fp11_mul_tb.sv
`timescale 1ns/1ps
module fp11_mul_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [10:0] op_a = '0, op_b = '0;
    logic        out_valid, ovf, unf, inv;
    logic [10:0] result;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fp11_mul u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf), .inv(inv)
    );

    // returns {result, ovf, unf, inv}
    function automatic logic [13:0] model(input logic [10:0] a, input logic [10:0] b);
        int ea, eb, ma, mb, p, k, mant, rem, half, e;
        logic s;
        ea = int'(a[9:6]); eb = int'(b[9:6]);
        s  = a[10] ^ b[10];
        if ((ea == 15 && a[5:0] != 0) || (eb == 15 && b[5:0] != 0))
            return {11'b0_1111_100000, 3'b000};
        if ((ea == 15 && eb == 0) || (ea == 0 && eb == 15))
            return {11'b0_1111_100000, 3'b001};
        if (ea == 15 || eb == 15) return {s, 4'hF, 6'd0, 3'b000};
        if (ea == 0 || eb == 0)   return {s, 10'd0, 3'b000};
        ma = 64 + int'(a[5:0]); mb = 64 + int'(b[5:0]);
        p  = ma * mb;
        k  = (p >= 8192) ? 7 : 6;
        e  = ea + eb - 7 + k - 6;
        mant = p >> k;
        rem  = p - (mant << k);
        half = 1 << (k - 1);
        if (rem > half || (rem == half && (mant % 2) == 1)) mant = mant + 1;
        if (mant == 128) begin mant = 64; e = e + 1; end
        if (e >= 15) return {s, 4'hF, 6'd0, 3'b100};
        if (e <= 0)  return {s, 10'd0, 3'b010};
        return {s, 4'(e), 6'(mant - 64), 3'b000};
    endfunction

    task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%b flags=%b expected res=%b flags=%b",
                     req, got[13:3], got[2:0], exp[13:3], exp[2:0]);
        end
    endtask

    task automatic mul(input string req, input logic [10:0] a, input logic [10:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, {result, ovf, unf, inv}, model(a, b));
        n_run++;
        if (out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: out_valid got %b expected 1", out_valid);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [13:0] held;
        void'($urandom(32'h5eed_0011));
        repeat (3) @(negedge clk);
        chk("R12", {result, ovf, unf, inv}, 14'd0);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: out_valid got %b expected 0", out_valid);
        end
        rst_n = 1'b1;

        mul("R1", 11'b0_0111_000000, 11'b0_0111_000000);   // 1.0 * 1.0
        mul("R1", 11'b0_1000_100000, 11'b0_0110_010000);   // 3.0 * 0.625
        mul("R2", 11'b1_0111_000000, 11'b0_1001_000000);
        mul("R2", 11'b1_0101_001100, 11'b1_1000_110011);
        mul("R3", 11'b0_0111_110000, 11'b0_0111_110000);   // 1.75^2
        mul("R4", 11'b0_0111_000001, 11'b0_0111_100000);   // tie, odd -> up
        mul("R4", 11'b0_0111_000010, 11'b0_0111_010000);   // tie, even -> stays
        mul("R5", 11'b0_0111_011010, 11'b0_0111_011011);   // rounds past 1.111111
        mul("R6", 11'b1_0000_101010, 11'b0_1010_000111);
        mul("R6", 11'b0_0000_000000, 11'b0_0000_000000);
        mul("R7", 11'b0_1111_000000, 11'b1_0000_000000);
        mul("R7", 11'b0_1111_010000, 11'b0_0111_000000);
        mul("R8", 11'b1_1111_000000, 11'b0_0011_000000);
        mul("R8", 11'b1_1111_000000, 11'b1_1111_000000);
        mul("R9", 11'b0_1110_000000, 11'b0_1000_000000);   // 14+8-7 = 15
        mul("R9", 11'b0_1110_111111, 11'b0_0111_111111);   // normalize into 15
        mul("R1", 11'b0_1110_000000, 11'b0_0111_000000);   // top normal 14
        mul("R10", 11'b1_0011_000000, 11'b0_0100_000000);  // 3+4-7 = 0
        mul("R1", 11'b0_0001_000000, 11'b0_0111_000000);   // bottom normal 1
        mul("R10", 11'b0_0001_000000, 11'b0_0001_000000);

        // R11: idle cycles keep outputs unchanged
        held = {result, ovf, unf, inv};
        op_a = 11'b0_1000_000000; op_b = 11'b0_1000_000000;
        repeat (2) @(negedge clk);
        chk("R11", {result, ovf, unf, inv}, held);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: out_valid got %b expected 0", out_valid);
        end

        for (int i = 0; i < 400; i++) begin
            logic [10:0] ra, rb;
            ra = 11'($urandom);
            rb = 11'($urandom);
            if (i % 2 == 0) begin
                ra[9:6] = 4'(5 + ($urandom % 5));
                rb[9:6] = 4'(5 + ($urandom % 5));
            end
            mul("R1", ra, rb);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule